// File: doc/BRIEF.md
# Responder Exit Resume Selector

This block runs inside each responding logical processor during a coordinated exit from a measured execution environment. Once the responder has acknowledged the exit, the block is armed and records a 3-bit code that describes what the processor was doing when the exit was recognised. It then waits for the continue message from the initiating processor and does nothing before that message arrives.

When the continue message arrives, the block unmasks the four external pin events (SMI, INIT, A20M, NMI). It also emits a one-cycle resume-action code that tells the core how to restart. The core may restart the pending instruction, go back into halt, leave a monitor-wait and fall through to the next instruction, or continue a string instruction from the iteration where it stopped. A responder that never woke from the enter-time sleep takes a separate path. It clears its bootstrap flag and any pending startup-IPI, requests a soft-reset style initialization for one cycle, unmasks the startup-IPI event and parks until a startup-IPI arrives. The contents of the architectural state are outside this block.

Top module: `rlp_exit_resume`

## Requirements
- R1: While idle the block ignores `contMsg`. A high `ackIn` in idle arms the block and captures `priorState`. Once armed, the block holds all outputs until `contMsg` is seen.
- R2: One cycle after `contMsg` is seen in the armed state, `pinMask` reads 4'b0000 and `actionValid` is high for exactly one cycle. The `pinMask` bits are bit0 SMI, bit1 INIT, bit2 A20M and bit3 NMI, and 1 means masked.
- R3: A captured prior code of 1 (halt) yields action code 2 (re-enter halt).
- R4: A captured prior code of 2 (monitor-wait) yields action code 3 (leave the wait and continue at the next instruction).
- R5: A captured prior code of 3 (mid-string) yields action code 4 (resume the string at the interrupted iteration).
- R6: A captured prior code of 0 (normal), or any of the unused codes 5, 6 or 7, yields action code 1 (restart the pending instruction).
- R7: A captured prior code of 4 (enter-sleep) yields action code 5 (wait for startup-IPI). In that case `initReq` and `clearBoot` are high in the same cycle as `actionValid`. They stay low on every other path.
- R8: `initReq` is never high for two consecutive cycles.
- R9: On the sleep path, `sipiMask` drops and `parked` rises one cycle after `initReq`. `parked` stays high until `sipiIn` is seen, and is low in the following cycle.
- R10: A second `ackIn` while the block is armed is ignored, and the first captured code is kept.
- R11: After reset, `pinMask` is 4'b1111 and `sipiMask` is 1. `actionValid`, `actionCode`, `initReq`, `clearBoot` and `parked` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ackIn | input | 1 | Exit acknowledged; arms the block |
| priorState | input | 3 | Prior execution state code, sampled with `ackIn` |
| contMsg | input | 1 | Continue message from the initiator |
| sipiIn | input | 1 | Startup-IPI arrival |
| actionCode | output | 3 | Selected resume action |
| actionValid | output | 1 | One-cycle strobe qualifying `actionCode` |
| pinMask | output | 4 | External pin event masks (1 = masked) |
| sipiMask | output | 1 | Startup-IPI event mask (1 = masked) |
| initReq | output | 1 | One-cycle soft-reset initialization request |
| clearBoot | output | 1 | One-cycle clear of bootstrap flag and pending startup-IPI |
| parked | output | 1 | Waiting for a startup-IPI |

## Verification
The main function is driven once with each of the eight prior-state codes. This separates the four named resume paths from each other. It also shows that the three unused codes fall back to a plain restart, and that only code 4 starts the re-initialization sequence. Directed patterns then send a continue message to an idle block, which must produce no action and leave the masks unchanged. They send a second acknowledge while the block is armed, which must keep the first code. Finally, they hold the parked state for several cycles without a startup-IPI before releasing it, which shows that only a startup-IPI ends the park.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int PRIOR_W = 3;
  localparam int ACT_W   = 3;

  typedef logic [PRIOR_W-1:0] prior_t;
  typedef logic [ACT_W-1:0]   act_t;

  // Prior execution state codes
  localparam prior_t PRIOR_NORMAL = 3'd0;
  localparam prior_t PRIOR_HALT   = 3'd1;
  localparam prior_t PRIOR_MWAIT  = 3'd2;
  localparam prior_t PRIOR_STRING = 3'd3;
  localparam prior_t PRIOR_SLEEP  = 3'd4;

  // Resume action codes
  localparam act_t ACT_NONE      = 3'd0;
  localparam act_t ACT_RESTART   = 3'd1;
  localparam act_t ACT_HALT      = 3'd2;
  localparam act_t ACT_NEXT      = 3'd3;
  localparam act_t ACT_STRING    = 3'd4;
  localparam act_t ACT_SIPI_WAIT = 3'd5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPrior;
    logic unmaskPins;
    logic emitAction;
    logic reinit;
    logic unmaskSipi;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_SIPIOPEN,
    ST_PARK
  } state_t;

endpackage

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ackIn,
  input  logic    contMsg,
  input  logic    sipiIn,
  input  logic    priorIsSleep,
  output strobe_t strb,
  output logic    parked
);

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (ackIn) begin
          strb.loadPrior = 1'b1;
          stateNext      = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (contMsg) begin
          strb.unmaskPins = 1'b1;
          strb.emitAction = 1'b1;
          if (priorIsSleep) begin
            strb.reinit = 1'b1;
            stateNext   = ST_SIPIOPEN;
          end else begin
            stateNext   = ST_IDLE;
          end
        end
      end
      ST_SIPIOPEN: begin
        strb.unmaskSipi = 1'b1;
        stateNext       = ST_PARK;
      end
      ST_PARK: begin
        if (sipiIn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign parked = (state == ST_PARK);

  // R1: an armed block keeps waiting while no continue message arrives
  p_armed_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED && !contMsg) |=> (state == ST_ARMED));

  // R9: the park is left only on a startup-IPI
  p_park_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PARK && !sipiIn) |=> (state == ST_PARK));

endmodule

// File: rtl/rxr_dp.sv
module rxr_dp
  import rxr_pkg::*;
#(
  parameter int PIN_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  prior_t               priorIn,
  input  strobe_t              strb,
  output logic                 priorIsSleep,
  output act_t                 actionCode,
  output logic                 actionValid,
  output logic [PIN_COUNT-1:0] pinMask,
  output logic                 sipiMask,
  output logic                 initReq,
  output logic                 clearBoot
);

  prior_t priorReg;
  act_t   actSel;

  always_ff @(posedge clk) begin
    if (!rst_n)              priorReg <= PRIOR_NORMAL;
    else if (strb.loadPrior) priorReg <= priorIn;
  end

  always_comb begin
    unique case (priorReg)
      PRIOR_HALT:   actSel = ACT_HALT;
      PRIOR_MWAIT:  actSel = ACT_NEXT;
      PRIOR_STRING: actSel = ACT_STRING;
      PRIOR_SLEEP:  actSel = ACT_SIPI_WAIT;
      default:      actSel = ACT_RESTART;
    endcase
  end

  assign priorIsSleep = (priorReg == PRIOR_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actionCode  <= ACT_NONE;
      actionValid <= 1'b0;
      initReq     <= 1'b0;
      clearBoot   <= 1'b0;
    end else begin
      actionValid <= strb.emitAction;
      initReq     <= strb.reinit;
      clearBoot   <= strb.reinit;
      if (strb.emitAction) actionCode <= actSel;
    end
  end

  // One mask register per pin event
  for (genvar g = 0; g < PIN_COUNT; g++) begin : gPinMask
    always_ff @(posedge clk) begin
      if (!rst_n)               pinMask[g] <= 1'b1;
      else if (strb.unmaskPins) pinMask[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               sipiMask <= 1'b1;
    else if (strb.unmaskSipi) sipiMask <= 1'b0;
  end

  // R7: an init request only comes with the wait-for-startup-IPI action
  p_init_only_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    initReq |-> (actionCode == ACT_SIPI_WAIT && actionValid));

  // R8: the init request is a single-cycle pulse
  p_init_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    initReq |=> !initReq);

endmodule

// File: rtl/rlp_exit_resume.sv
module rlp_exit_resume
  import rxr_pkg::*;
#(
  parameter int PIN_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ackIn,
  input  logic [2:0]           priorState,
  input  logic                 contMsg,
  input  logic                 sipiIn,
  output logic [2:0]           actionCode,
  output logic                 actionValid,
  output logic [PIN_COUNT-1:0] pinMask,
  output logic                 sipiMask,
  output logic                 initReq,
  output logic                 clearBoot,
  output logic                 parked
);

  strobe_t strb;
  logic    priorIsSleep;

  rxr_ctrl uCtrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ackIn        (ackIn),
    .contMsg      (contMsg),
    .sipiIn       (sipiIn),
    .priorIsSleep (priorIsSleep),
    .strb         (strb),
    .parked       (parked)
  );

  rxr_dp #(.PIN_COUNT(PIN_COUNT)) uDp (
    .clk          (clk),
    .rst_n        (rst_n),
    .priorIn      (priorState),
    .strb         (strb),
    .priorIsSleep (priorIsSleep),
    .actionCode   (actionCode),
    .actionValid  (actionValid),
    .pinMask      (pinMask),
    .sipiMask     (sipiMask),
    .initReq      (initReq),
    .clearBoot    (clearBoot)
  );

  // R1: no action without a continue message one cycle earlier
  p_act_needs_cont_r1: assert property (@(posedge clk) disable iff (!rst_n)
    actionValid |-> $past(contMsg));

  // R2: whenever an action is issued the pin events are already unmasked
  p_pins_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    actionValid |-> (pinMask == '0));

  // R9: a parked responder has its startup-IPI event unmasked
  p_park_unmasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> !sipiMask);

  // R9: the park begins right after the init request
  p_park_after_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    initReq |=> (parked && !sipiMask));

endmodule

// File: tb/rlp_exit_resume_test.sv
module rlp_exit_resume_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ackIn = 1'b0;
  logic [2:0] priorState = 3'd0;
  logic       contMsg = 1'b0;
  logic       sipiIn = 1'b0;
  logic [2:0] actionCode;
  logic       actionValid;
  logic [3:0] pinMask;
  logic       sipiMask;
  logic       initReq;
  logic       clearBoot;
  logic       parked;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rlp_exit_resume uut (
    .clk(clk), .rst_n(rst_n), .ackIn(ackIn), .priorState(priorState),
    .contMsg(contMsg), .sipiIn(sipiIn), .actionCode(actionCode),
    .actionValid(actionValid), .pinMask(pinMask), .sipiMask(sipiMask),
    .initReq(initReq), .clearBoot(clearBoot), .parked(parked)
  );

  // {prior, expected action, expected init}
  localparam logic [6:0] VEC [8] = '{
    {3'd0, 3'd1, 1'b0},  // R6
    {3'd1, 3'd2, 1'b0},  // R3
    {3'd2, 3'd3, 1'b0},  // R4
    {3'd3, 3'd4, 1'b0},  // R5
    {3'd4, 3'd5, 1'b1},  // R7
    {3'd5, 3'd1, 1'b0},  // R6
    {3'd6, 3'd1, 1'b0},  // R6
    {3'd7, 3'd1, 1'b0}   // R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0; ackIn = 1'b0; contMsg = 1'b0; sipiIn = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic arm(input logic [2:0] code);
    @(negedge clk); ackIn = 1'b1; priorState = code;
    @(negedge clk); ackIn = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    doReset();
    @(negedge clk);
    check(pinMask == 4'b1111, "R11 pinMask", pinMask, 15);
    check(sipiMask == 1'b1, "R11 sipiMask", sipiMask, 1);
    check({actionValid, actionCode, initReq, clearBoot, parked} == '0, "R11 outputs",
          {actionValid, actionCode, initReq, clearBoot, parked}, 0);

    // Table walk over all prior codes
    for (int i = 0; i < 8; i++) begin
      logic [2:0] pc, ec;
      logic       ei;
      {pc, ec, ei} = VEC[i];
      doReset();
      arm(pc);
      contMsg = 1'b1;
      @(negedge clk); contMsg = 1'b0;
      check(actionValid == 1'b1, "R2 actionValid", actionValid, 1);
      check(pinMask == 4'b0000, "R2 pinMask", pinMask, 0);
      check(actionCode == ec, "R3-R7 actionCode", actionCode, ec);
      check(initReq == ei, "R7 initReq", initReq, ei);
      check(clearBoot == ei, "R7 clearBoot", clearBoot, ei);
      @(negedge clk);
      check(actionValid == 1'b0, "R2 pulse width", actionValid, 0);
      check(initReq == 1'b0, "R8 initReq width", initReq, 0);
      check(sipiMask == !ei, "R9 sipiMask", sipiMask, !ei);
      check(parked == ei, "R9 parked", parked, ei);
      if (ei) begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          check(parked == 1'b1, "R9 park hold", parked, 1);
        end
        sipiIn = 1'b1;
        @(negedge clk); sipiIn = 1'b0;
        check(parked == 1'b0, "R9 park release", parked, 0);
      end
    end

    // R1: continue while idle has no effect
    doReset();
    @(negedge clk); contMsg = 1'b1;
    @(negedge clk); contMsg = 1'b0;
    check(actionValid == 1'b0, "R1 idle continue valid", actionValid, 0);
    check(pinMask == 4'b1111, "R1 idle continue mask", pinMask, 15);
    // R1: armed block waits without continue
    arm(3'd3);
    for (int k = 0; k < 3; k++) @(negedge clk);
    check(actionValid == 1'b0 && pinMask == 4'b1111, "R1 armed wait", actionValid, 0);
    contMsg = 1'b1;
    @(negedge clk); contMsg = 1'b0;
    check(actionCode == 3'd4, "R1 armed then continue", actionCode, 4);

    // R10: second acknowledge while armed is ignored
    doReset();
    arm(3'd1);
    @(negedge clk); ackIn = 1'b1; priorState = 3'd4;
    @(negedge clk); ackIn = 1'b0; contMsg = 1'b1;
    @(negedge clk); contMsg = 1'b0;
    check(actionCode == 3'd2, "R10 first code kept", actionCode, 2);
    check(initReq == 1'b0, "R10 no init", initReq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule